// File: doc/BRIEF.md
# ISA I/O Cycle Sequencer

This block is the bus-master side of a 16-bit I/O transfer on an ISA-style expansion bus. A requester hands it one read or one write. The sequencer then runs the bus cycle: address phase, command strobe, slave handshakes and write-data hold. When the cycle is over it returns a single response. The block is clocked at twice the bus clock rate, so each bus clock is split into a first half and a second half. Every bus event is placed on a bus clock edge or a bus clock midpoint.

The request side uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A requester that holds `req_valid` high while the sequencer is busy is stalled, and its fields are neither sampled nor used. The response side has no back-pressure: `rsp_valid` pulses for exactly one clock and the requester must take `rsp_rdata` in that cycle.

The slave's 16-bit acknowledge is sampled once per cycle. If it is absent, the sequencer raises `steer_req` so that external byte-steering logic can act. This block only reports the need and does not steer any bytes. The slave ready line can stretch the cycle one bus clock at a time. The "no wait state" shortcut is never honoured on I/O cycles, so an I/O cycle never runs shorter than three bus clocks.

Top module: `isa_io_seq`

## Requirements
- R1: `addr_strobe` is high for exactly one fast clock, in the second half of the address phase (the 2nd fast cycle after acceptance). `sys_addr` shows the accepted address zero-extended to 20 bits from that cycle through the last data-clock cycle. It is stable in that window and reads zero at all other times.
- R2: `lat_addr_hi` (upper address bits 23:17) is always zero.
- R3: For a write (`req_write`=1), `dbus_oe` is high and `dbus_out` carries the write data. This starts at the address-phase midpoint and lasts through the first half of the following address phase, which is one fast cycle past the command. For a read, `dbus_oe` stays low.
- R4: `io_rd_n` (read) or `io_wr_n` (write), both active low, goes low at the midpoint of the first data clock and stays low to the end of the last data clock. The two are never low together.
- R5: `slave_wide_n` is sampled only at the midpoint of the second data clock. If it is sampled high, `steer_req` is high from that point until the response cycle ends. Otherwise `steer_req` stays low. Its value at all other times has no effect.
- R6: `chan_ready` is sampled only at the end of the second data clock and at the end of each later data clock. A low sample adds one data clock (two fast cycles). Its value at all other times has no effect.
- R7: With `chan_ready` high at its first sample, the cycle from address phase to the end of the command takes exactly three bus clocks (six fast clocks). No input shortens it.
- R8: `rsp_valid` is high for exactly one fast clock, the one right after the last data clock. `rsp_rdata` then holds the `dbus_in` value that was present during the last fast cycle of the data phase.
- R9: `req_ready` is high only when idle, which begins one fast clock after the response. Requests presented while busy are ignored, and the cycle under way keeps its address, direction and data.
- R10: After reset, `req_ready` is high, both commands are high, and `addr_strobe`, `dbus_oe`, `rsp_valid` and `steer_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | I/O address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data captured at cycle end |
| addr_strobe | output | 1 | Address latch enable to the bus |
| sys_addr | output | 20 | Latched bus address |
| lat_addr_hi | output | 7 | Unlatched upper address bits, zero for I/O |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| dbus_out | output | 16 | Data bus drive value |
| dbus_oe | output | 1 | Data bus output enable |
| dbus_in | input | 16 | Data bus value from the slave |
| slave_wide_n | input | 1 | Slave 16-bit acknowledge, active low |
| chan_ready | input | 1 | Slave ready, low stretches the cycle |
| steer_req | output | 1 | Slave answered as 8-bit, steering needed |

## Verification
Two events can fall on the same edge. A stretched cycle can finish at the very edge where read data is captured. The width sample sits on the edge just before the first ready sample, so a high sample there can coincide with a ready sample that ends the cycle. The bench sets the ready wait count per transaction and drives random values on both slave lines in every cycle that is not a sample point. It also floods the request port while a cycle is busy. Each sampled cycle is compared with a per-cycle expected waveform that bench functions derive from the chosen wait count, direction and width answer.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;
  // fast-clock phases: each bus clock is a LO half then a HI half
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TS0  = 3'd1,
    PH_TS1  = 3'd2,
    PH_TC0  = 3'd3,
    PH_TC1  = 3'd4,
    PH_END  = 3'd5
  } phase_e;

  // which data clock is under way
  typedef enum logic [1:0] {
    DC_FIRST  = 2'd0,
    DC_SECOND = 2'd1,
    DC_EXTRA  = 2'd2
  } dclk_e;
endpackage

// File: rtl/isa_io_phase_fsm.sv
module isa_io_phase_fsm
  import isa_io_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   slave_wide_n,
  input  logic   chan_ready,
  output phase_e phase,
  output dclk_e  dclk,
  output logic   steer,
  output logic   finish
);
  // The last data clock ends on a ready sample taken in any data clock
  // from the second on.
  assign finish = (phase == PH_TC1) && (dclk != DC_FIRST) && chan_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      dclk  <= DC_FIRST;
      steer <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          steer <= 1'b0;
          if (start) phase <= PH_TS0;
        end
        PH_TS0: phase <= PH_TS1;
        PH_TS1: begin
          phase <= PH_TC0;
          dclk  <= DC_FIRST;
        end
        PH_TC0: begin
          phase <= PH_TC1;
          // midpoint of the second data clock: width acknowledge sample
          if (dclk == DC_SECOND) steer <= slave_wide_n;
        end
        PH_TC1: begin
          if (dclk == DC_FIRST) begin
            dclk  <= DC_SECOND;
            phase <= PH_TC0;
          end else if (chan_ready) begin
            phase <= PH_END;
          end else begin
            dclk  <= DC_EXTRA;
            phase <= PH_TC0;
          end
        end
        PH_END: begin
          phase <= PH_IDLE;
          steer <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isa_io_cmd_gen.sv
module isa_io_cmd_gen
  import isa_io_pkg::*;
(
  input  phase_e phase,
  input  dclk_e  dclk,
  input  logic   is_write,
  output logic   addr_strobe,
  output logic   addr_drive,
  output logic   io_rd_n,
  output logic   io_wr_n,
  output logic   data_drive,
  output logic   rsp_valid,
  output logic   req_ready
);
  logic cmd_on;

  always_comb begin
    addr_strobe = (phase == PH_TS1);
    addr_drive  = (phase == PH_TS1) || (phase == PH_TC0) || (phase == PH_TC1);
    // command starts at the midpoint of the first data clock
    cmd_on      = (phase == PH_TC1) || ((phase == PH_TC0) && (dclk != DC_FIRST));
    io_rd_n     = !(cmd_on && !is_write);
    io_wr_n     = !(cmd_on && is_write);
    // write data is held one half clock past the command
    data_drive  = is_write && ((phase == PH_TS1) || (phase == PH_TC0) ||
                               (phase == PH_TC1) || (phase == PH_END));
    rsp_valid   = (phase == PH_END);
    req_ready   = (phase == PH_IDLE);
  end
endmodule

// File: rtl/isa_io_datapath.sv
module isa_io_datapath #(
  parameter int ADDR_W = 16,
  parameter int SA_W   = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              finish,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dbus_in,
  input  logic              addr_drive,
  output logic              is_write,
  output logic [SA_W-1:0]   sys_addr,
  output logic [DATA_W-1:0] dbus_out,
  output logic [DATA_W-1:0] rdata
);
  localparam int SA_PAD = SA_W - ADDR_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [SA_W-1:0]   addr_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      is_write <= 1'b0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
        is_write <= req_write;
      end
      if (finish) rdata <= dbus_in;
    end
  end

  generate
    if (SA_PAD > 0) begin : g_pad
      assign addr_ext = {{SA_PAD{1'b0}}, addr_q};
    end else begin : g_nopad
      assign addr_ext = addr_q[SA_W-1:0];
    end
  endgenerate

  assign sys_addr = addr_drive ? addr_ext : '0;
  assign dbus_out = wdata_q;
endmodule

// File: rtl/isa_io_seq.sv
module isa_io_seq
  import isa_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SA_W   = 20,
  parameter int LA_W   = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              addr_strobe,
  output logic [SA_W-1:0]   sys_addr,
  output logic [LA_W-1:0]   lat_addr_hi,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic [DATA_W-1:0] dbus_out,
  output logic              dbus_oe,
  input  logic [DATA_W-1:0] dbus_in,
  input  logic              slave_wide_n,
  input  logic              chan_ready,
  output logic              steer_req
);
  phase_e phase;
  dclk_e  dclk;
  logic   accept, finish, is_write, addr_drive;

  assign accept      = req_valid && req_ready;
  assign lat_addr_hi = '0;   // I/O space never uses the upper bits

  isa_io_phase_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .slave_wide_n (slave_wide_n),
    .chan_ready   (chan_ready),
    .phase        (phase),
    .dclk         (dclk),
    .steer        (steer_req),
    .finish       (finish)
  );

  isa_io_cmd_gen u_cmd (
    .phase       (phase),
    .dclk        (dclk),
    .is_write    (is_write),
    .addr_strobe (addr_strobe),
    .addr_drive  (addr_drive),
    .io_rd_n     (io_rd_n),
    .io_wr_n     (io_wr_n),
    .data_drive  (dbus_oe),
    .rsp_valid   (rsp_valid),
    .req_ready   (req_ready)
  );

  isa_io_datapath #(
    .ADDR_W (ADDR_W),
    .SA_W   (SA_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .finish     (finish),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .dbus_in    (dbus_in),
    .addr_drive (addr_drive),
    .is_write   (is_write),
    .sys_addr   (sys_addr),
    .dbus_out   (dbus_out),
    .rdata      (rsp_rdata)
  );
endmodule

// File: rtl/isa_io_seq_chk.sv
module isa_io_seq_chk #(
  parameter int SA_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            addr_strobe,
  input logic [SA_W-1:0] sys_addr,
  input logic            io_rd_n,
  input logic            io_wr_n,
  input logic            dbus_oe,
  input logic            steer_req
);
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_strobe) |=> !addr_strobe);

  p_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd_n || !io_wr_n) |-> $stable(sys_addr));

  p_cmd_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!io_rd_n && !io_wr_n));

  p_cmd_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_strobe) |=> (!io_rd_n || !io_wr_n));

  p_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_wr_n) |-> dbus_oe);

  p_cmd_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_rd_n) |=> !io_rd_n ##1 !io_rd_n);

  p_steer_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_req && !rsp_valid) |=> steer_req);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!io_rd_n || !io_wr_n));

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe || !io_rd_n || !io_wr_n || rsp_valid) |-> !req_ready);
endmodule

bind isa_io_seq isa_io_seq_chk #(.SA_W(SA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .addr_strobe (addr_strobe),
  .sys_addr    (sys_addr),
  .io_rd_n     (io_rd_n),
  .io_wr_n     (io_wr_n),
  .dbus_oe     (dbus_oe),
  .steer_req   (steer_req)
);

// File: tb/tb_isa_io_seq.sv
`timescale 1ns/1ps
module tb_isa_io_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        addr_strobe;
  logic [19:0] sys_addr;
  logic [6:0]  lat_addr_hi;
  logic        io_rd_n, io_wr_n;
  logic [15:0] dbus_out;
  logic        dbus_oe;
  logic [15:0] dbus_in;
  logic        slave_wide_n, chan_ready;
  logic        steer_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  isa_io_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .addr_strobe(addr_strobe),
    .sys_addr(sys_addr), .lat_addr_hi(lat_addr_hi), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
    .dbus_in(dbus_in), .slave_wide_n(slave_wide_n), .chan_ready(chan_ready),
    .steer_req(steer_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected waveforms, cycle c counted from the accepting edge (c=1 first)
  function automatic bit e_strobe(int c);           return c == 2; endfunction
  function automatic bit e_addr(int c, int last);   return c >= 2 && c <= last; endfunction
  function automatic bit e_cmd(int c, int last);    return c >= 4 && c <= last; endfunction
  function automatic bit e_oe(bit wr, int c, int last);
    return wr && c >= 2 && c <= last + 1;
  endfunction
  function automatic bit e_steer(bit narrow, int c, int last);
    return narrow && c >= 6 && c <= last + 1;
  endfunction

  task automatic run_txn(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input int waits, input bit narrow, input bit flood);
    int last;
    logic [15:0] rd_exp;
    last   = 6 + 2 * waits;
    rd_exp = '0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 idle ready", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    slave_wide_n = 1'($urandom); chan_ready = 1'($urandom); dbus_in = 16'($urandom);
    for (int c = 1; c <= last + 2; c++) begin
      @(negedge clk);
      chk(addr_strobe == e_strobe(c), "R1 strobe", 32'(addr_strobe), 32'(e_strobe(c)));
      chk(sys_addr == (e_addr(c, last) ? {4'h0, a} : 20'h0), "R1 R9 address",
          32'(sys_addr), e_addr(c, last) ? 32'(a) : 0);
      chk(lat_addr_hi == 7'h0, "R2 upper zero", 32'(lat_addr_hi), 0);
      chk(dbus_oe == e_oe(wr, c, last), "R3 drive", 32'(dbus_oe), 32'(e_oe(wr, c, last)));
      if (dbus_oe) chk(dbus_out == d, "R3 R9 write data", 32'(dbus_out), 32'(d));
      // R6 stretch and R7 three-bus-clock minimum show in the command window
      chk(io_rd_n == !(!wr && e_cmd(c, last)), "R4 R6 R7 read cmd",
          32'(io_rd_n), 32'(!(!wr && e_cmd(c, last))));
      chk(io_wr_n == !(wr && e_cmd(c, last)), "R4 R6 R7 write cmd",
          32'(io_wr_n), 32'(!(wr && e_cmd(c, last))));
      chk(steer_req == e_steer(narrow, c, last), "R5 steer",
          32'(steer_req), 32'(e_steer(narrow, c, last)));
      chk(rsp_valid == (c == last + 1), "R8 response", 32'(rsp_valid), 32'(c == last + 1));
      if (c == last + 1) chk(rsp_rdata == rd_exp, "R8 read data", 32'(rsp_rdata), 32'(rd_exp));
      chk(req_ready == (c == last + 2), "R9 ready", 32'(req_ready), 32'(c == last + 2));
      // drive inputs for this cycle
      if (flood && c <= last) begin
        req_valid = 1'b1; req_write = 1'($urandom);
        req_addr = 16'($urandom); req_wdata = 16'($urandom);
      end else begin
        req_valid = 1'b0;
      end
      slave_wide_n = (c == 5) ? narrow : 1'($urandom);
      chan_ready   = (c >= 6 && c % 2 == 0) ? (c >= last) : 1'($urandom);
      dbus_in      = 16'($urandom);
      if (c == last) rd_exp = dbus_in;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    dbus_in = '0; slave_wide_n = 1'b0; chan_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 1);
    chk(io_rd_n && io_wr_n, "R10 commands", {30'h0, io_rd_n, io_wr_n}, 3);
    chk(!addr_strobe && !dbus_oe && !rsp_valid && !steer_req, "R10 outputs",
        {28'h0, addr_strobe, dbus_oe, rsp_valid, steer_req}, 0);
    rst_n = 1'b1;
    // directed corners
    run_txn(1'b0, 16'h03F8, 16'h0000, 0, 1'b0, 1'b0);  // R7 minimum read
    run_txn(1'b1, 16'h0378, 16'hA55A, 0, 1'b0, 1'b0);  // R3 minimum write
    run_txn(1'b1, 16'h0060, 16'h1234, 0, 1'b1, 1'b0);  // R5 narrow, end on first ready sample
    run_txn(1'b0, 16'hFFFF, 16'h0000, 3, 1'b1, 1'b1);  // R6 stretched, R9 flood
    run_txn(1'b1, 16'h0001, 16'hFFFF, 1, 1'b0, 1'b1);
    run_txn(1'b1, 16'h0002, 16'h0F0F, 0, 1'b0, 1'b0);  // back-to-back writes
    for (int i = 0; i < 40; i++)
      run_txn(1'($urandom), 16'($urandom), 16'($urandom), int'($urandom % 5),
              1'($urandom), 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule